// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Transfer-Register Window

This block keeps calendar time in binary coded decimal: seconds, minutes, hours (24-hour), weekday, day of month, month, two-digit year and a century flag. A prescaler turns a 32,768 Hz enable pulse into a one-second step. The stepping handles month lengths and leap years itself. A stop flag freezes both the chain and its prescaler.

Software sees ten byte registers through a byte-wide burst port. That port stands in for a two-wire slave with device address 68h (D0h once the read/write bit is appended). The live counters are never reached directly. A read burst captures every register into a snapshot when it starts and returns bytes from that snapshot. A write burst collects bytes in staging registers and commits all of them to the counters in one cycle when the burst ends. A calibration byte carries a 6-bit value and a bit that drives a discrete output pin.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the ten registers read 00h 00h 00h 01h 01h 01h 00h 00h 00h 00h at addresses 0 to 9, and `out_pin` is low.
- R2: A burst begins only when `xfer_dev` equals 68h. A begin with any other device value does not start a burst: its writes change no register, and `rdata` stays 00h while no read burst is open.
- R3: Bit 7 of register 0 is the stop flag. While it is 1, seconds do not advance, whatever the number of enable pulses. After it is cleared, the count resumes.
- R4: Register 0 bits 6:0 hold seconds, register 1 bits 6:0 hold minutes, and register 2 bits 5:0 hold hours. Each is BCD with carries 59->00, 59->00 and 23->00. Register 3 holds the weekday 1..7, which steps at midnight and wraps 7->1.
- R5: Register 4 holds the day of month and register 5 the month, both BCD. Months 04, 06, 09 and 11 end after day 30, February after day 28 or 29, and all other months after day 31. Day and month restart at 01, and month 12 rolls to 01 while the year in register 6 steps.
- R6: A year whose BCD value is divisible by four, 00 included, gives February 29 days. Other years give February 28 days.
- R7: Register 2 bit 7 enables the century bit, which is register 2 bit 6. When the enable is 1, the century bit toggles as the year rolls from 99 to 00. When the enable is 0, the century bit does not change.
- R8: A read burst returns the values the registers held in the cycle the burst began, even if the time advances during the burst.
- R9: Written bytes have no effect until `xfer_end`. All bytes written in the burst take effect together in the cycle after it.
- R10: The register address is loaded at burst begin, with addresses 10 to 15 treated as 0. It steps after each byte and wraps from 9 to 0.
- R11: Writing register 0 restarts the one-second prescaler. The next step of the seconds then comes a full second of enable pulses after the write.
- R12: Registers 7 and 9 read 00h and ignore writes. In register 8, bit 6 reads 0 and bits 5:0 read back the stored value.
- R13: `out_pin` follows bit 7 of register 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32,768 Hz rate |
| xfer_begin | input | 1 | Start of a burst (start condition plus device byte) |
| xfer_dev | input | 7 | Device address carried with the begin |
| xfer_read | input | 1 | 1 for a read burst, 0 for a write burst |
| xfer_addr | input | 4 | Starting register address |
| byte_wr | input | 1 | Write strobe for one data byte |
| byte_wdata | input | 8 | Data byte to write |
| byte_rd | input | 1 | Read strobe; the address steps after the byte |
| xfer_end | input | 1 | End of burst (stop condition) |
| rdata | output | 8 | Snapshot byte at the current address |
| out_pin | output | 1 | Discrete output level |

## Verification
The hardest case to reach from the ports is a rollover that ripples through every field on one enable pulse. With the default prescaler it would take years of simulated time. The bench overrides the prescaler division to a few pulses and writes a time one second before each boundary: end of a 30-day and a 31-day month, February in leap and common years, and year 99 with the century enable on and off. It then checks all seven time bytes after exactly one second of pulses. Snapshot coherence is checked by holding a read burst open while a second elapses.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NREG   = 10;
  localparam int unsigned AW     = 4;
  localparam logic [6:0]  DEV_ID = 7'h68;

  typedef struct packed {
    logic       stop;
    logic       cen_en;
    logic       cent;
    logic       outb;
    logic [5:0] cal;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] day;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic halt,
  input  logic clr,
  output logic pulse
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign pulse = tick && !halt && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (tick && !halt) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11: a restart never lets a step through on the following cycle
  a_r11_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse);
endmodule

// File: rtl/rtc_timechain.sv
module rtc_timechain
  import rtc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sec_pulse,
  input  logic [NREG-1:0]            ld_mask,
  input  logic [NREG-1:0][7:0]       ld_byte,
  output logic [NREG-1:0][7:0]       img,
  output logic                       stop,
  output logic                       outb
);
  localparam rtc_time_t RST_TIME = '{stop: 1'b0, cen_en: 1'b0, cent: 1'b0, outb: 1'b0,
                                     cal: 6'h00, sec: 8'h00, min: 8'h00, hr: 8'h00,
                                     day: 8'h01, date: 8'h01, mon: 8'h01, yr: 8'h00};

  rtc_time_t cur, nx;
  logic c_sec, c_min, c_hr, c_date, c_mon, c_yr;
  logic unused_bits;

  assign c_sec  = cur.sec == 8'h59;
  assign c_min  = c_sec && (cur.min == 8'h59);
  assign c_hr   = c_min && (cur.hr == 8'h23);
  assign c_date = c_hr && (cur.date == month_len(cur.mon, cur.yr));
  assign c_mon  = c_date && (cur.mon == 8'h12);
  assign c_yr   = c_mon && (cur.yr == 8'h99);

  always_comb begin
    nx = cur;
    if (sec_pulse) begin
      nx.sec = c_sec ? 8'h00 : bcd_inc(cur.sec);
      if (c_sec) nx.min = c_min ? 8'h00 : bcd_inc(cur.min);
      if (c_min) nx.hr  = c_hr  ? 8'h00 : bcd_inc(cur.hr);
      if (c_hr) begin
        nx.day  = (cur.day == 8'h07) ? 8'h01 : cur.day + 8'd1;
        nx.date = c_date ? 8'h01 : bcd_inc(cur.date);
      end
      if (c_date) nx.mon = c_mon ? 8'h01 : bcd_inc(cur.mon);
      if (c_mon)  nx.yr  = c_yr  ? 8'h00 : bcd_inc(cur.yr);
      if (c_yr && cur.cen_en) nx.cent = ~cur.cent;
    end
    if (ld_mask[0]) begin nx.stop = ld_byte[0][7]; nx.sec = {1'b0, ld_byte[0][6:0]}; end
    if (ld_mask[1]) nx.min = {1'b0, ld_byte[1][6:0]};
    if (ld_mask[2]) begin
      nx.cen_en = ld_byte[2][7];
      nx.cent   = ld_byte[2][6];
      nx.hr     = {2'b0, ld_byte[2][5:0]};
    end
    if (ld_mask[3]) nx.day  = {5'b0, ld_byte[3][2:0]};
    if (ld_mask[4]) nx.date = {2'b0, ld_byte[4][5:0]};
    if (ld_mask[5]) nx.mon  = {3'b0, ld_byte[5][4:0]};
    if (ld_mask[6]) nx.yr   = ld_byte[6];
    if (ld_mask[8]) begin nx.outb = ld_byte[8][7]; nx.cal = ld_byte[8][5:0]; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= RST_TIME;
    else        cur <= nx;
  end

  assign img[0] = {cur.stop, cur.sec[6:0]};
  assign img[1] = {1'b0, cur.min[6:0]};
  assign img[2] = {cur.cen_en, cur.cent, cur.hr[5:0]};
  assign img[3] = {5'b0, cur.day[2:0]};
  assign img[4] = {2'b0, cur.date[5:0]};
  assign img[5] = {3'b0, cur.mon[4:0]};
  assign img[6] = cur.yr;
  assign img[7] = 8'h00;
  assign img[8] = {cur.outb, 1'b0, cur.cal};
  assign img[9] = 8'h00;
  assign stop   = cur.stop;
  assign outb   = cur.outb;

  assign unused_bits = ^{ld_mask[7], ld_mask[9], ld_byte[7], ld_byte[9], ld_byte[1][7],
                         ld_byte[3][7:3], ld_byte[4][7:6], ld_byte[5][7:5], ld_byte[8][6],
                         cur.sec[7], cur.min[7], cur.hr[7:6], cur.day[7:3],
                         cur.date[7:6], cur.mon[7:5]};

  // R3: a stopped chain keeps its seconds unless software writes them
  a_r3_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.stop && !ld_mask[0]) |=> $stable(cur.sec));
  // R4: a step at 59 seconds lands on 00
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && (cur.sec == 8'h59) && !ld_mask[0]) |=> (cur.sec == 8'h00));
  // R7: the century bit moves only on an enabled 99->00 year step or a write
  a_r7_century_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_mask[2] && !(sec_pulse && cur.cen_en && (cur.yr == 8'h99))) |=> $stable(cur.cent));
endmodule

// File: rtl/rtc_xfer.sv
module rtc_xfer
  import rtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_begin,
  input  logic [6:0]           xfer_dev,
  input  logic                 xfer_read,
  input  logic [AW-1:0]        xfer_addr,
  input  logic                 byte_wr,
  input  logic [7:0]           byte_wdata,
  input  logic                 byte_rd,
  input  logic                 xfer_end,
  input  logic [NREG-1:0][7:0] img,
  output logic [7:0]           rdata,
  output logic [NREG-1:0][7:0] ld_byte,
  output logic [NREG-1:0]      ld_mask
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic                 act_q, act_d, rd_q, rd_d;
  logic [AW-1:0]        ptr_q, ptr_d, ptr_inc;
  logic [NREG-1:0][7:0] snap_q, snap_d, stage_q, stage_d;
  logic [NREG-1:0]      dirty_q, dirty_d;
  logic                 beg_ok;

  assign beg_ok  = xfer_begin && (xfer_dev == DEV_ID);
  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_comb begin
    act_d = act_q; rd_d = rd_q; ptr_d = ptr_q;
    snap_d = snap_q; stage_d = stage_q; dirty_d = dirty_q;
    if (beg_ok) begin
      act_d   = 1'b1;
      rd_d    = xfer_read;
      ptr_d   = (int'(xfer_addr) < NREG) ? xfer_addr : '0;
      dirty_d = '0;
      if (xfer_read) snap_d = img;
    end else if (act_q) begin
      if (xfer_end) begin
        act_d   = 1'b0;
        dirty_d = '0;
      end else if (rd_q && byte_rd) begin
        ptr_d = ptr_inc;
      end else if (!rd_q && byte_wr) begin
        stage_d[ptr_q] = byte_wdata;
        dirty_d[ptr_q] = 1'b1;
        ptr_d          = ptr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; rd_q <= 1'b0; ptr_q <= '0;
      snap_q <= '0; stage_q <= '0; dirty_q <= '0;
    end else begin
      act_q <= act_d; rd_q <= rd_d; ptr_q <= ptr_d;
      snap_q <= snap_d; stage_q <= stage_d; dirty_q <= dirty_d;
    end
  end

  assign rdata   = (act_q && rd_q) ? snap_q[ptr_q] : 8'h00;
  assign ld_byte = stage_q;
  assign ld_mask = (act_q && !rd_q && xfer_end && !beg_ok) ? dirty_q : '0;

  // R10: the register pointer never leaves the ten-byte window
  a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NREG);
  // R8: an open read burst keeps its captured image
  a_r8_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && rd_q && !beg_ok) |=> $stable(snap_q));
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       xfer_begin,
  input  logic [6:0] xfer_dev,
  input  logic       xfer_read,
  input  logic [3:0] xfer_addr,
  input  logic       byte_wr,
  input  logic [7:0] byte_wdata,
  input  logic       byte_rd,
  input  logic       xfer_end,
  output logic [7:0] rdata,
  output logic       out_pin
);
  logic                 rst_meta, rst_sync;
  logic                 sec_pulse, stop;
  logic [NREG-1:0]      ld_mask;
  logic [NREG-1:0][7:0] ld_byte, img;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_meta <= 1'b0; rst_sync <= 1'b0; end
    else        begin rst_meta <= 1'b1; rst_sync <= rst_meta; end
  end

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_sync), .tick(tick_32k), .halt(stop),
    .clr(ld_mask[0]), .pulse(sec_pulse));

  rtc_timechain u_chain (
    .clk(clk), .rst_n(rst_sync), .sec_pulse(sec_pulse), .ld_mask(ld_mask),
    .ld_byte(ld_byte), .img(img), .stop(stop), .outb(out_pin));

  rtc_xfer u_xfer (
    .clk(clk), .rst_n(rst_sync), .xfer_begin(xfer_begin), .xfer_dev(xfer_dev),
    .xfer_read(xfer_read), .xfer_addr(xfer_addr), .byte_wr(byte_wr),
    .byte_wdata(byte_wdata), .byte_rd(byte_rd), .xfer_end(xfer_end),
    .img(img), .rdata(rdata), .ld_byte(ld_byte), .ld_mask(ld_mask));
endmodule

// File: tb/rtc_bcd_core_test.sv
module rtc_bcd_core_test;
  localparam int DIV = 8;
  localparam logic [6:0] DEV = 7'h68;
  // {sec,min,hr,day,date,mon,yr} start, then expected after one second
  localparam logic [111:0] VEC [15] = '{
    112'h00000001010100_01000001010100,
    112'h59592307311299_00000001010100,
    112'h59592303300424_00000004010524,
    112'h59592302280223_00000003010323,
    112'h59592302280224_00000003290224,
    112'h59592302290224_00000003010324,
    112'h59592305310105_00000006010205,
    112'h5959A307311299_0000C001010100,
    112'h5959E302311299_00008003010100,
    112'h09591204150610_10591204150610,
    112'h59091204150610_00101204150610,
    112'h59592301280200_00000002290200,
    112'h59590901300919_00001001300919,
    112'h59592306300921_00000007011021,
    112'h59592304301121_00000005011221
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, xb = 1'b0, xr = 1'b0, bw = 1'b0, br = 1'b0, xe = 1'b0;
  logic [6:0] xd = '0;
  logic [3:0] xa = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, v;
  logic out_pin;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rtc_bcd_core #(.PRESC_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .xfer_begin(xb), .xfer_dev(xd),
    .xfer_read(xr), .xfer_addr(xa), .byte_wr(bw), .byte_wdata(wd), .byte_rd(br),
    .xfer_end(xe), .rdata(rdata), .out_pin(out_pin));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_begin(input logic [6:0] dev, input logic rd, input logic [3:0] a);
    @(negedge clk); xb = 1'b1; xd = dev; xr = rd; xa = a;
    @(negedge clk); xb = 1'b0;
  endtask
  task automatic bus_wr(input logic [7:0] b);
    @(negedge clk); bw = 1'b1; wd = b;
    @(negedge clk); bw = 1'b0;
  endtask
  task automatic bus_rd(output logic [7:0] b);
    @(negedge clk); b = rdata; br = 1'b1;
    @(negedge clk); br = 1'b0;
  endtask
  task automatic bus_end();
    @(negedge clk); xe = 1'b1;
    @(negedge clk); xe = 1'b0;
  endtask
  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask
  task automatic put(input logic [3:0] a, input logic [7:0] b);
    bus_begin(DEV, 1'b0, a); bus_wr(b); bus_end();
  endtask
  task automatic get(input logic [3:0] a, output logic [7:0] b);
    bus_begin(DEV, 1'b1, a); bus_rd(b); bus_end();
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset image
    chk("R1 out_pin", {7'b0, out_pin}, 8'h00);
    bus_begin(DEV, 1'b1, 4'd0);
    for (int i = 0; i < 10; i++) begin
      bus_rd(v);
      chk("R1 reset image", v, (i >= 3 && i <= 5) ? 8'h01 : 8'h00);
    end
    bus_end();

    // Table walk: R4 R5 R6 R7 rollovers after exactly one second
    for (int k = 0; k < 15; k++) begin
      bus_begin(DEV, 1'b0, 4'd0);
      for (int i = 0; i < 7; i++) bus_wr(VEC[k][111-8*i -: 8]);
      bus_end();
      run_ticks(DIV);
      bus_begin(DEV, 1'b1, 4'd0);
      for (int i = 0; i < 7; i++) begin
        bus_rd(v);
        chk($sformatf("table R4 R5 R6 R7 vector %0d byte %0d", k, i), v, VEC[k][55-8*i -: 8]);
      end
      bus_end();
    end

    // R3: stop flag freezes seconds, clearing it resumes
    put(4'd0, 8'h90);
    run_ticks(3*DIV);
    get(4'd0, v); chk("R3 stopped", v, 8'h90);
    put(4'd0, 8'h10);
    run_ticks(DIV);
    get(4'd0, v); chk("R3 resumed", v, 8'h11);

    // R11: writing seconds restarts the prescaler
    put(4'd0, 8'h20);
    run_ticks(DIV-3);
    put(4'd0, 8'h30);
    run_ticks(DIV-1);
    get(4'd0, v); chk("R11 before full second", v, 8'h30);
    run_ticks(1);
    get(4'd0, v); chk("R11 at full second", v, 8'h31);

    // R2: other device address is ignored
    put(4'd0, 8'h31);
    bus_begin(7'h50, 1'b0, 4'd0); bus_wr(8'h45); bus_end();
    get(4'd0, v); chk("R2 foreign write", v, 8'h31);
    bus_begin(7'h50, 1'b1, 4'd0); bus_rd(v); bus_end();
    chk("R2 foreign read", v, 8'h00);

    // R8: snapshot held while a second elapses during the burst
    put(4'd0, 8'h00);
    bus_begin(DEV, 1'b1, 4'd0);
    run_ticks(DIV);
    bus_rd(v); chk("R8 snapshot", v, 8'h00);
    bus_end();
    get(4'd0, v); chk("R8 fresh read", v, 8'h01);

    // R10: wrap 9->0 on read and write; begin address above 9 maps to 0
    bus_begin(DEV, 1'b0, 4'd0);
    bus_wr(8'h12); bus_wr(8'h34); bus_wr(8'h05);
    bus_end();
    bus_begin(DEV, 1'b1, 4'd9);
    bus_rd(v); chk("R10 read at 9", v, 8'h00);
    bus_rd(v); chk("R10 read wraps to 0", v, 8'h12);
    bus_rd(v); chk("R10 read 1", v, 8'h34);
    bus_end();
    bus_begin(DEV, 1'b0, 4'd9); bus_wr(8'hAA); bus_wr(8'h07); bus_end();
    get(4'd0, v); chk("R10 write wraps to 0", v, 8'h07);
    get(4'd12, v); chk("R10 begin above 9", v, 8'h07);

    // R9 R13: output bit applied only at end of burst
    bus_begin(DEV, 1'b0, 4'd8); bus_wr(8'h80);
    @(negedge clk); xe = 1'b1;
    chk("R9 not before end", {7'b0, out_pin}, 8'h00);
    @(negedge clk); xe = 1'b0;
    chk("R13 out_pin high", {7'b0, out_pin}, 8'h01);
    get(4'd8, v); chk("R9 cal readback", v, 8'h80);

    // R12: reserved registers and bit 6 of register 8
    bus_begin(DEV, 1'b0, 4'd7);
    bus_wr(8'h55); bus_wr(8'h7F); bus_wr(8'h55);
    bus_end();
    chk("R13 out_pin low", {7'b0, out_pin}, 8'h00);
    bus_begin(DEV, 1'b1, 4'd7);
    bus_rd(v); chk("R12 reg 7", v, 8'h00);
    bus_rd(v); chk("R12 reg 8", v, 8'h3F);
    bus_rd(v); chk("R12 reg 9", v, 8'h00);
    bus_end();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule